// File: doc/BRIEF.md
# Integer ALU with comparison flags

This block is the combinational arithmetic logic unit of a small RISC-V style integer core. It takes two operands, `opa_i` and `opb_i`, and a 4-bit operation code, `op_i`. From these it produces one data result, `res_o`. The operations are addition, subtraction, bitwise AND, bitwise XOR and three shifts. There is also a jump-register target add, which clears bit 0 of the sum. A compare-only code drives the result to zero, so that a branch unit can use the flags on their own.

Three comparison flags are computed on every evaluation, whatever the code:

- equality
- signed less-than
- unsigned less-than

The block has no clock and no state. The surrounding pipeline registers its outputs.

Top module: `int_alu`

## Requirements
- R1: Code 0 drives `res_o` to opa + opb modulo 2^W, with no overflow indication.
- R2: Code 1 drives `res_o` to opa - opb modulo 2^W; for example 0xffff8000 - 0x7fffffff = 0x7fff8001.
- R3: Code 2 drives `res_o` to the bitwise AND of the operands.
- R4: Code 4 drives `res_o` to the bitwise XOR of the operands.
- R5: Code 7 shifts opa left and code 6 shifts opa right, both logically and filling with zeros. The amount is opb[4:0], and the upper bits of opb are ignored.
- R6: Code 5 shifts opa right by opb[4:0] and copies the sign bit into the vacated positions; 0x80000000 by 14 gives 0xfffe0000, and 0x7fffffff by 14 gives 0x0001ffff.
- R7: Code 10 drives `res_o` to opa + opb with bit 0 forced to zero; 0x00132050 + 0x45 gives 0x00132094.
- R8: Code 14 drives `res_o` to all zeros.
- R9: `eq_o` is 1 exactly when opa equals opb.
- R10: `lt_o` is 1 exactly when opa < opb as two's-complement values; 0xfff0a440 is less than 0x00004450.
- R11: `ltu_o` is 1 exactly when opa < opb as unsigned values, and it is 0 when the operands are equal.
- R12: Codes 3, 8, 9, 11, 12, 13 and 15 drive `res_o` to all zeros.
- R13: The three flags depend only on the operands; the same operands give the same flags under every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | W (32) | First operand; the value that is shifted |
| opb_i | input | W (32) | Second operand; its low 5 bits are the shift amount |
| op_i | input | 4 | Operation code |
| res_o | output | W (32) | Data result |
| eq_o | output | 1 | Operands equal |
| lt_o | output | 1 | opa below opb, signed |
| ltu_o | output | 1 | opa below opb, unsigned |

## Verification
The block holds no state, so a wrong internal path cannot persist. It shows up at the ports as soon as the inputs settle, and only for the codes or operand patterns that use that path. A wrong shift multiplexer, for example, changes `res_o` only for some shift amounts. A missing sign fill shows only when opa is negative. A flag decoded from the wrong adder bit shows only when the operand signs differ. The stimulus therefore mixes sign-boundary and equal-operand cases with random operands under all sixteen codes.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         eq_o,
  output logic         lt_o,
  output logic         ltu_o
);
  localparam int SHW = $clog2(W);

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_SUB = 4'd1;
  localparam logic [3:0] OP_AND = 4'd2;
  localparam logic [3:0] OP_XOR = 4'd4;
  localparam logic [3:0] OP_SRA = 4'd5;
  localparam logic [3:0] OP_SRL = 4'd6;
  localparam logic [3:0] OP_SLL = 4'd7;
  localparam logic [3:0] OP_JTG = 4'd10;
  localparam logic [3:0] OP_CMP = 4'd14;

  logic [SHW-1:0] shamt;
  logic [W-1:0]   sum, diff, sll_v, srl_v, sra_v;
  logic [W:0]     diff_x;

  assign shamt  = opb_i[SHW-1:0];
  assign sum    = opa_i + opb_i;
  assign diff_x = {1'b0, opa_i} - {1'b0, opb_i};
  assign diff   = diff_x[W-1:0];
  assign sll_v  = opa_i << shamt;
  assign srl_v  = opa_i >> shamt;
  assign sra_v  = W'($signed(opa_i) >>> shamt);

  assign eq_o  = (opa_i == opb_i);
  assign ltu_o = diff_x[W];
  assign lt_o  = (opa_i[W-1] != opb_i[W-1]) ? opa_i[W-1] : diff_x[W];

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = sum;
      OP_SUB:  res_o = diff;
      OP_AND:  res_o = opa_i & opb_i;
      OP_XOR:  res_o = opa_i ^ opb_i;
      OP_SRA:  res_o = sra_v;
      OP_SRL:  res_o = srl_v;
      OP_SLL:  res_o = sll_v;
      OP_JTG:  res_o = {sum[W-1:1], 1'b0};
      OP_CMP:  res_o = '0;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] res_o,
  input logic         eq_o,
  input logic         lt_o,
  input logic         ltu_o
);
  always_comb begin
    if (!$isunknown({opa_i, opb_i, op_i, res_o, eq_o, lt_o, ltu_o})) begin
      AST_CMP_ZERO:  assert (op_i != 4'd14 || res_o == '0);                                  // R8
      AST_JTG_EVEN:  assert (op_i != 4'd10 || res_o[0] == 1'b0);                             // R7
      AST_AND_SUBSET: assert (op_i != 4'd2 || ((res_o & ~opa_i) == '0 && (res_o & ~opb_i) == '0)); // R3
      AST_ADD_INV:   assert (op_i != 4'd0 || res_o - opb_i == opa_i);                        // R1
      AST_SUB_INV:   assert (op_i != 4'd1 || res_o + opb_i == opa_i);                        // R2
      AST_EQ_EXCL:   assert (!eq_o || (!lt_o && !ltu_o));                                    // R11
      AST_SAME_SIGN: assert (opa_i[W-1] != opb_i[W-1] || lt_o == ltu_o);                     // R10
      AST_SRA_SIGN:  assert (op_i != 4'd5 || res_o[W-1] == opa_i[W-1]);                      // R6
    end
  end
endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (.*);

// File: tb/int_alu_tb.sv
module int_alu_tb;
  localparam int W = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [W-1:0] a, b;
  logic [3:0]   op;
  logic [W-1:0] res;
  logic         eq, lt, ltu;

  int checks = 0;
  int errors = 0;

  int_alu #(.W(W)) u_dut (
    .opa_i(a), .opb_i(b), .op_i(op),
    .res_o(res), .eq_o(eq), .lt_o(lt), .ltu_o(ltu)
  );

  function automatic logic [W-1:0] ref_sra(input logic [W-1:0] x, input int n);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i + n < W) ? x[i + n] : x[W-1];
    return r;
  endfunction

  function automatic logic [W-1:0] ref_res(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic [3:0] c);
    int n;
    n = int'(y[4:0]);
    case (c)
      4'd0:  return x + y;
      4'd1:  return x + (~y) + 1;
      4'd2:  return x & y;
      4'd4:  return x ^ y;
      4'd5:  return ref_sra(x, n);
      4'd6:  return x >> n;
      4'd7:  return x << n;
      4'd10: return (x + y) & ~W'(1);
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd0: return "R1";  4'd1: return "R2";  4'd2: return "R3";  4'd4: return "R4";
      4'd5: return "R6";  4'd6: return "R5";  4'd7: return "R5";  4'd10: return "R7";
      4'd14: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic [3:0] c);
    @(posedge clk);
    a = x; b = y; op = c;
    @(negedge clk);
  endtask

  task automatic chk_res(input string t, input logic [W-1:0] exp);
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h res actual=%h expected=%h", t, op, a, b, res, exp);
    end
  endtask

  task automatic chk_flags;
    logic e_eq, e_lt, e_ltu;
    e_eq  = (a == b);
    e_ltu = (a < b);
    e_lt  = ($signed(a) < $signed(b));
    checks++;
    if (eq !== e_eq) begin errors++; $display("FAIL R9 eq actual=%b expected=%b", eq, e_eq); end
    checks++;
    if (lt !== e_lt) begin errors++; $display("FAIL R10 lt actual=%b expected=%b", lt, e_lt); end
    checks++;
    if (ltu !== e_ltu) begin errors++; $display("FAIL R11 ltu actual=%b expected=%b", ltu, e_ltu); end
  endtask

  task automatic run(input logic [W-1:0] x, input logic [W-1:0] y, input logic [3:0] c);
    apply(x, y, c);
    chk_res(tag_of(c), ref_res(x, y, c));
    chk_flags();
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    a = '0; b = '0; op = 4'd0;
    @(negedge clk);
    chk_res("R1", '0);   // idle state, all zero inputs
    chk_flags();

    run(32'h0ffaa660, 32'h00012304, 4'd0);            // R1
    apply(32'hfeeeeaa3, 32'hf4650000, 4'd0); chk_res("R1", 32'hf353eaa3);
    apply(32'hffff8000, 32'h7fffffff, 4'd1); chk_res("R2", 32'h7fff8001);
    apply(32'h00000001, 32'hffffffff, 4'd1); chk_res("R2", 32'h00000002);
    apply(32'h00132050, 32'hd6620040, 4'd2); chk_res("R3", 32'h00020040);
    apply(32'h0ffaa660, 32'h00012304, 4'd4); chk_res("R4", 32'h0ffb8564);
    apply(32'hfffffffd, 32'h00000007, 4'd7); chk_res("R5", 32'hfffffe80);
    apply(32'hffffff9c, 32'h00000001, 4'd6); chk_res("R5", 32'h7fffffce);
    apply(32'h80000000, 32'hffffffee, 4'd6); chk_res("R5", 32'h00020000); // upper b ignored
    apply(32'h00008001, 32'h1234560b, 4'd7); chk_res("R5", 32'h04000800);
    apply(32'h80000000, 32'h0000000e, 4'd5); chk_res("R6", 32'hfffe0000);
    apply(32'h7fffffff, 32'h0000000e, 4'd5); chk_res("R6", 32'h0001ffff);
    apply(32'h80000000, 32'h0000001f, 4'd5); chk_res("R6", 32'hffffffff);
    apply(32'h00132050, 32'h00000045, 4'd10); chk_res("R7", 32'h00132094);
    apply(32'hfeeeeaa3, 32'h000004de, 4'd10); chk_res("R7", 32'hfeeeef80);
    apply(32'h00132050, 32'hd6620040, 4'd14); chk_res("R8", '0);
    if (ltu !== 1'b1) begin errors++; $display("FAIL R11 ltu actual=%b expected=1", ltu); end
    checks++;
    apply(32'hfeeeeaa3, 32'hfeeeeaa3, 4'd14); chk_res("R8", '0);
    if (ltu !== 1'b0 || eq !== 1'b1) begin
      errors++; $display("FAIL R11 equal ops ltu/eq actual=%b%b expected=01", ltu, eq);
    end
    checks++;
    apply(32'hfff0a440, 32'h00004450, 4'd3); chk_res("R12", '0);
    if (lt !== 1'b1 || ltu !== 1'b0) begin
      errors++; $display("FAIL R10 lt/ltu actual=%b%b expected=10", lt, ltu);
    end
    checks++;

    // R13: same operands, every code, identical flags
    for (int c = 0; c < 16; c++) run(32'h80000001, 32'h7ffffffe, 4'(c));
    for (int c = 0; c < 16; c++) run(32'h5a5a5a5a, 32'h5a5a5a5a, 4'(c));

    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] x, y;
      x = $urandom();
      y = $urandom();
      if (i % 7 == 0) y = x;
      if (i % 11 == 0) y = {x[W-1], y[W-2:0]};
      run(x, y, 4'($urandom_range(0, 15)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule